// File: doc/BRIEF.md
# Encoded Power-of-Two CPU Clock Divider

This block generates the CPU clock-enable from the master clock. A free-running binary counter provides power-of-two taps, and a 3-bit speed code selects one of eight of them through an 8-to-1 selector. The selected tap is registered in the master-clock domain, so the CPU sees a clean enable that is high for one master-clock cycle in every N cycles. It never sees a divided clock. The default code gives one eighth of the master rate, which is 3 MHz from a 24 MHz source.

The code is not ordered by ratio. The four low codes select the fast rates and the four high codes select the slow rates, and one ratio (/64) cannot be selected. A code written through the strobe is held as pending. It becomes active only at the end of the enable period in progress, and the divider chain then restarts. Because of this, a rate change never produces a short or merged enable period. An output reports the code that is currently active.

Top module: `pow2_cpu_rate_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `cpu_en` is 0 and `rate_active` is 000. The first enable after reset is high in the 8th cycle after the cycle in which `rst` is sampled low.
- R2: Each speed code gives a fixed enable period N: 000=/8, 001=/4, 010=/2, 011=/1, 100=/16, 101=/32, 110=/128, 111=/256. In steady state, consecutive enable pulses are exactly N cycles apart.
- R3: For N greater than 1, each enable pulse lasts exactly one master-clock cycle. For N equal to 1 (code 011), `cpu_en` stays high in every cycle.
- R4: A code on `rate_code` is captured when `rate_wr` is high at a clock edge. `rate_active` keeps its old value until the current enable period ends, and that period completes at the old length.
- R5: `rate_active` takes the new code in the same cycle as the last enable pulse of the old rate. The next pulse follows exactly N_new cycles later.
- R6: If a second write arrives before the pending code has been applied, it replaces the first. Only the last code written becomes active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_code | input | 3 | Speed code to write |
| rate_wr | input | 1 | Write strobe for `rate_code` |
| cpu_en | output | 1 | Registered CPU clock-enable pulse |
| rate_active | output | 3 | Speed code currently in effect |

## Verification
`cpu_en` is driven from a register one edge after the counter reaches the selected tap, and `rate_active` changes on the edge that closes a period. The new code is therefore visible in the same cycle as the last old pulse, and the first new pulse arrives exactly N cycles later. The bench drives inputs and samples outputs on falling edges. It measures every gap by counting falling edges from one pulse to the next. The expected gaps come from the code table: eight after reset, N_old before a switch, and N_new after it.

// File: rtl/pow2_div_pkg.sv
package pow2_div_pkg;
  localparam int CODE_W  = 3;
  localparam int SHIFT_W = 4;

  // Speed code to log2 of divide ratio; /64 (shift 6) is unreachable.
  function automatic logic [SHIFT_W-1:0] code_shift(input logic [CODE_W-1:0] code);
    logic [SHIFT_W-1:0] s;
    case (code)
      3'b000:  s = 4'd3;
      3'b001:  s = 4'd2;
      3'b010:  s = 4'd1;
      3'b011:  s = 4'd0;
      3'b100:  s = 4'd4;
      3'b101:  s = 4'd5;
      3'b110:  s = 4'd7;
      default: s = 4'd8;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/pow2_div_chain.sv
module pow2_div_chain #(
  parameter int CNT_W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           restart,
  output logic [CNT_W:0] taps
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  // taps[k] is high when the low k counter bits are all ones.
  assign taps[0] = 1'b1;
  for (genvar k = 1; k <= CNT_W; k++) begin : g_tap
    assign taps[k] = &cnt_q[k-1:0];
  end
endmodule

// File: rtl/rate_tap_mux.sv
module rate_tap_mux #(
  parameter int CNT_W   = 8,
  parameter int SHIFT_W = 4
) (
  input  logic [CNT_W:0]   taps,
  input  logic [SHIFT_W-1:0] shift,
  output logic             tap_sel
);
  always_comb begin
    tap_sel = 1'b0;
    for (int i = 0; i <= CNT_W; i++)
      if (shift == SHIFT_W'(i)) tap_sel = taps[i];
  end
endmodule

// File: rtl/pow2_cpu_rate_gen.sv
module pow2_cpu_rate_gen
  import pow2_div_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              rate_wr,
  output logic              cpu_en,
  output logic [CODE_W-1:0] rate_active
);
  logic [CODE_W-1:0]  act_q, pend_q;
  logic               pend_vld_q, en_q;
  logic [CNT_W:0]     taps;
  logic [SHIFT_W-1:0] shift;
  logic               period_end, apply;

  assign shift      = code_shift(act_q);
  assign apply      = period_end && pend_vld_q;

  pow2_div_chain #(.CNT_W(CNT_W)) chain_i (
    .clk(clk), .rst(rst), .restart(apply), .taps(taps)
  );

  rate_tap_mux #(.CNT_W(CNT_W), .SHIFT_W(SHIFT_W)) mux_i (
    .taps(taps), .shift(shift), .tap_sel(period_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q      <= '0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      en_q       <= 1'b0;
    end else begin
      en_q <= period_end;
      if (apply) act_q <= pend_q;
      if (rate_wr) begin
        pend_q     <= rate_code;
        pend_vld_q <= 1'b1;
      end else if (apply) begin
        pend_vld_q <= 1'b0;
      end
    end
  end

  assign cpu_en      = en_q;
  assign rate_active = act_q;

  // R3
  en_single_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_en && act_q != 3'b011) |=> !cpu_en);
  // R3
  unit_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q == 3'b011 && $past(act_q) == 3'b011 && !$past(rst)) |-> cpu_en);
  // R5
  switch_on_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_q) |-> cpu_en);
  // R4
  switch_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_q) |-> $past(pend_vld_q));
  // R4
  wr_pending_chk: assert property (@(posedge clk) disable iff (rst)
    rate_wr |=> pend_vld_q);
endmodule

// File: tb/pow2_cpu_rate_gen_tb.sv
module pow2_cpu_rate_gen_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] rate_code = '0;
  logic rate_wr = 1'b0;
  logic cpu_en;
  logic [2:0] rate_active;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  pow2_cpu_rate_gen dut_i (
    .clk(clk), .rst(rst), .rate_code(rate_code), .rate_wr(rate_wr),
    .cpu_en(cpu_en), .rate_active(rate_active)
  );

  localparam logic [2:0] SEQ_CODE [8] = '{3'd3, 3'd5, 3'd0, 3'd7, 3'd2, 3'd4, 3'd1, 3'd6};
  localparam int         SEQ_N    [8] = '{1, 32, 8, 256, 2, 16, 4, 128};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // From a negedge, count negedges until cpu_en is seen high.
  task automatic gap_to_pulse(output int gap);
    gap = 0;
    do begin
      @(negedge clk); gap++;
    end while (!cpu_en && gap < 1000);
  endtask

  task automatic write_code(input logic [2:0] c);
    rate_code = c; rate_wr = 1'b1;
    @(negedge clk);
    rate_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        finish_run();
      end
    end
  end

  initial begin
    int g, t;
    bit held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cpu_en == 1'b0, "R1 en in reset", cpu_en, 0);
    check(rate_active == 3'd0, "R1 code in reset", rate_active, 0);
    rst = 1'b0;
    gap_to_pulse(g);
    check(g == 8, "R1 first pulse after reset", g, 8);
    gap_to_pulse(g);
    check(g == 8, "R2 default /8 period", g, 8);

    // Table walk: R2, R3, R5
    for (int i = 0; i < 8; i++) begin
      write_code(SEQ_CODE[i]);
      t = 0;
      while (rate_active != SEQ_CODE[i] && t < 600) begin
        @(negedge clk); t++;
      end
      check(rate_active == SEQ_CODE[i], "R5 code applied", rate_active, SEQ_CODE[i]);
      check(cpu_en == 1'b1, "R5 switch with old pulse", cpu_en, 1);
      gap_to_pulse(g);
      check(g == SEQ_N[i], "R5 first new period", g, SEQ_N[i]);
      gap_to_pulse(g);
      check(g == SEQ_N[i], "R2 steady period", g, SEQ_N[i]);
      @(negedge clk);
      if (SEQ_N[i] > 1) check(cpu_en == 1'b0, "R3 single-cycle pulse", cpu_en, 0);
      else              check(cpu_en == 1'b1, "R3 /1 stays high", cpu_en, 1);
    end

    // R4/R6: under /256, write twice mid-period; old period completes.
    write_code(3'd7);
    t = 0;
    while (rate_active != 3'd7 && t < 600) begin @(negedge clk); t++; end
    check(rate_active == 3'd7, "R4 setup /256", rate_active, 7);
    g = 0;
    held = 1'b1;
    repeat (10) begin @(negedge clk); g++; end
    write_code(3'd2); g++;
    repeat (10) begin
      @(negedge clk); g++;
      if (rate_active != 3'd7 || cpu_en) held = 1'b0;
    end
    write_code(3'd1); g++;
    check(rate_active == 3'd7, "R4 active held before boundary", rate_active, 7);
    check(held, "R4 no early switch or pulse", held, 1);
    while (!cpu_en && g < 1000) begin @(negedge clk); g++; end
    check(g == 256, "R4 old period completes", g, 256);
    check(rate_active == 3'd1, "R6 last write wins", rate_active, 1);
    gap_to_pulse(g);
    check(g == 4, "R6 new /4 period", g, 4);

    // R1: reset mid-run
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(cpu_en == 1'b0 && rate_active == 3'd0, "R1 mid-run reset", rate_active, 0);
    rst = 1'b0;
    gap_to_pulse(g);
    check(g == 8, "R1 first pulse after second reset", g, 8);

    finish_run();
  end
endmodule